// File: doc/BRIEF.md
# Dual-Clock FIFO with Two-Level Reset and Rewind

This block is a first-in first-out buffer whose write side and read side run on independent clocks. Words enter on the write clock and leave on the read clock. The depth is a parameter and is kept small for simulation. The word width defaults to 9 bits. Each side keeps its own pointer. Each pointer crosses to the other side as Gray code through a two-flop synchronizer. Each side computes its own status flags from its own pointer and the synchronized copy of the other pointer.

A full reset picks the output timing mode and loads a default pair of threshold offsets. In standard mode a word appears on the output one read-clock edge after a read strobe. In fall-through mode the oldest word sits on the output with no strobe. A pointer-only reset empties the buffer but keeps the mode and the offsets. A rewind strobe moves the read pointer back to location zero, so the stored words can be read a second time. The almost-empty and almost-full thresholds live in a small offset bank on the write clock. After a full reset the bank holds a default pair. It can then be reloaded through the data input.

Top module: `dualclk_fifo`

## Requirements
- R1: While `rst_all_n` is low on clock edges, both pointers clear to location 0. Once it is released, the buffer is empty. In standard mode `out_flag`=1, `in_flag`=0, `half_full`=0, `almost_full`=0, `almost_empty`=1 and `dout`=0.
- R2: The level of `fall_thru` during a full reset selects the mode: 0 gives standard mode and 1 gives fall-through mode. In standard mode `out_flag` is 1 when empty and `in_flag` is 1 when full. In fall-through mode `out_flag` is 1 when a word is ready and `in_flag` is 1 when space is free.
- R3: In standard mode, a read strobe (`rd_en_n`=0) on a non-empty buffer puts the oldest word on `dout` just after that read-clock edge. Words come out in the order they were written.
- R4: In fall-through mode, the oldest word is on `dout` with no read strobe. A read strobe advances `dout` to the next word just after that edge.
- R5: A write while full changes neither the pointer nor the stored data. A read while empty changes neither the read pointer nor `dout`.
- R6: The full indication changes on the write edge that stores the DEPTH-th word. The empty indication changes on the read edge that takes the last word.
- R7: `half_full` is 1 when the write-side fill level is greater than DEPTH/2.
- R8: `almost_empty` is 1 when the read-side fill level is at most the empty offset. `almost_full` is 1 when the write-side fill level is at least DEPTH minus the full offset.
- R9: During a full reset, `ofs_ld_n`=0 loads empty/full offsets of 2/3. `ofs_ld_n`=1 loads offsets of 5/6.
- R10: A write-clock edge with `ofs_ld_n`=0 and `wr_en_n`=0 loads `din[AW-1:0]` into the offset bank and stores nothing in the buffer. The first such load after a reset sets the empty offset, the next sets the full offset, and then they alternate.
- R11: While `rst_ptr_n` is low on clock edges, both pointers clear to 0 and the buffer reads as empty. The mode and the offset values stay as they were.
- R12: `rewind_n` low on a read-clock edge sets the read pointer to location 0. Reads then return the words again from the first one.
- R13: A write into an empty buffer clears the empty indication within 3 read-clock edges. A read from a full buffer clears the full indication within 3 write-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_all_n | input | 1 | Full reset, active low, sampled on both clocks |
| rst_ptr_n | input | 1 | Pointer-only reset, active low, sampled on both clocks |
| fall_thru | input | 1 | Mode select, sampled during full reset |
| wr_en_n | input | 1 | Write strobe, active low |
| ofs_ld_n | input | 1 | Offset load select, also the default-pair select during full reset |
| din | input | DW | Write data, low AW bits also carry offset values |
| rd_en_n | input | 1 | Read strobe, active low |
| rewind_n | input | 1 | Rewind strobe, active low |
| dout | output | DW | Read data |
| out_flag | output | 1 | Empty (standard mode) or output ready (fall-through mode) |
| in_flag | output | 1 | Full (standard mode) or input ready (fall-through mode) |
| half_full | output | 1 | More than half of the locations in use |
| almost_empty | output | 1 | Fill level within the empty offset |
| almost_full | output | 1 | Fill level within the full offset of full |

## Verification
Flags computed on the same side as a stimulus are due just after that stimulus's own clock edge. This covers full after a write, empty after a read, standard-mode `dout` after a read, and fall-through `dout` after a read or rewind. The bench samples these half a nanosecond after that edge. Flags that depend on the other side's pointer are due two to three edges of the other clock after the stimulus. For these, the bench waits six write-clock periods before comparing against a fill level it tracks itself. R13 is checked differently: the bench counts the other clock's edges until the flag moves and requires at most three.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} fmode_t;

  // Pointer helpers work on 16-bit containers; callers cast to their width.
  function automatic logic [15:0] bin_to_gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [15:0] gray_to_bin(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // Distance from lag to lead, modulo 2**pw.
  function automatic logic [15:0] ptr_gap(input logic [15:0] lead,
                                          input logic [15:0] lag,
                                          input int pw);
    logic [15:0] m;
    m = 16'((32'd1 << pw) - 32'd1);
    return (lead - lag) & m;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (clr) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/dcf_ofs.sv
`timescale 1ns/1ps
module dcf_ofs #(
  parameter int AW       = 4,
  parameter int OFS_E_LO = 2,
  parameter int OFS_F_LO = 3,
  parameter int OFS_E_HI = 5,
  parameter int OFS_F_HI = 6
) (
  input  logic          clk,
  input  logic          rst_all_n,
  input  logic          rst_ptr_n,
  input  logic          ld_n,
  input  logic          en_n,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] ofs_e,
  output logic [AW-1:0] ofs_f
);
  logic next_is_full;
  logic load_evt;

  assign load_evt = !ld_n && !en_n;

  always_ff @(posedge clk) begin
    if (!rst_all_n) begin
      ofs_e        <= ld_n ? AW'(OFS_E_HI) : AW'(OFS_E_LO);
      ofs_f        <= ld_n ? AW'(OFS_F_HI) : AW'(OFS_F_LO);
      next_is_full <= 1'b0;
    end else if (!rst_ptr_n) begin
      next_is_full <= 1'b0;
    end else if (load_evt) begin
      if (next_is_full) ofs_f <= din;
      else              ofs_e <= din;
      next_is_full <= !next_is_full;
    end
  end
endmodule

// File: rtl/dcf_wside.sv
`timescale 1ns/1ps
module dcf_wside import dcf_pkg::*; #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_req,
  input  logic [AW:0]   rgray_s,
  input  logic [AW-1:0] ofs_f,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          half_full,
  output logic          almost_full,
  output logic          we,
  output logic [AW-1:0] wa
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rbin_s;
  logic [PW-1:0] level;
  logic [PW-1:0] wbin_nx;

  assign rbin_s  = PW'(gray_to_bin(16'(rgray_s)));
  assign level   = PW'(ptr_gap(16'(wbin), 16'(rbin_s), PW));
  assign full    = (level == PW'(DEPTH));
  assign half_full   = (level > PW'(DEPTH / 2));
  assign almost_full = (level >= (PW'(DEPTH) - PW'(ofs_f)));
  assign we      = wr_req && !full;
  assign wa      = wbin[AW-1:0];
  assign wbin_nx = wbin + PW'(1);

  always_ff @(posedge clk) begin
    if (clr) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin_nx;
      wgray <= PW'(bin_to_gray(16'(wbin_nx)));
    end
  end
endmodule

// File: rtl/dcf_rside.sv
`timescale 1ns/1ps
module dcf_rside import dcf_pkg::*; #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          rd_req,
  input  logic          rewind,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ofs_e,
  input  logic [DW-1:0] head,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic          empty,
  output logic          almost_empty,
  output logic [AW-1:0] ra,
  output logic [DW-1:0] q_std
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin_s;
  logic [PW-1:0] level;
  logic [PW-1:0] rbin_nx;
  logic          pop;

  assign wbin_s  = PW'(gray_to_bin(16'(wgray_s)));
  assign level   = PW'(ptr_gap(16'(wbin_s), 16'(rbin), PW));
  assign empty   = (level == '0);
  assign almost_empty = (level <= PW'(ofs_e));
  assign pop     = rd_req && !empty;
  assign ra      = rbin[AW-1:0];
  assign rbin_nx = rbin + PW'(1);

  always_ff @(posedge clk) begin
    if (clr) begin
      rbin  <= '0;
      rgray <= '0;
      q_std <= '0;
    end else if (rewind) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rbin  <= rbin_nx;
      rgray <= PW'(bin_to_gray(16'(rbin_nx)));
      q_std <= head;
    end
  end
endmodule

// File: rtl/dualclk_fifo.sv
`timescale 1ns/1ps
module dualclk_fifo import dcf_pkg::*; #(
  parameter int DW       = 9,
  parameter int AW       = 4,
  parameter int OFS_E_LO = 2,
  parameter int OFS_F_LO = 3,
  parameter int OFS_E_HI = 5,
  parameter int OFS_F_HI = 6
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_all_n,
  input  logic          rst_ptr_n,
  input  logic          fall_thru,
  input  logic          wr_en_n,
  input  logic          ofs_ld_n,
  input  logic [DW-1:0] din,
  input  logic          rd_en_n,
  input  logic          rewind_n,
  output logic [DW-1:0] dout,
  output logic          out_flag,
  output logic          in_flag,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  // Named internal events, also observed by the bound checker.
  logic          clr_w, clr_r;
  logic          wr_req, rd_req, rewind;
  logic          full_w, empty_r;
  logic [PW-1:0] wbin, rbin, wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] ofs_e, ofs_f;
  logic          we;
  logic [AW-1:0] wa, ra;
  logic [DW-1:0] head, q_std;
  fmode_t        mode_w, mode_r;
  logic [DW-1:0] mem [DEPTH];

  assign clr_w  = !rst_all_n || !rst_ptr_n;
  assign clr_r  = !rst_all_n || !rst_ptr_n;
  assign wr_req = !wr_en_n && ofs_ld_n;
  assign rd_req = !rd_en_n;
  assign rewind = !rewind_n;

  always_ff @(posedge wr_clk) begin
    if (!rst_all_n) mode_w <= fall_thru ? MODE_FWFT : MODE_STD;
  end

  always_ff @(posedge rd_clk) begin
    if (!rst_all_n) mode_r <= fall_thru ? MODE_FWFT : MODE_STD;
  end

  dcf_ofs #(
    .AW(AW), .OFS_E_LO(OFS_E_LO), .OFS_F_LO(OFS_F_LO),
    .OFS_E_HI(OFS_E_HI), .OFS_F_HI(OFS_F_HI)
  ) u_ofs (
    .clk(wr_clk), .rst_all_n(rst_all_n), .rst_ptr_n(rst_ptr_n),
    .ld_n(ofs_ld_n), .en_n(wr_en_n), .din(din[AW-1:0]),
    .ofs_e(ofs_e), .ofs_f(ofs_f)
  );

  dcf_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .clr(clr_r), .din(wgray), .dout(wgray_s)
  );

  dcf_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .clr(clr_w), .din(rgray), .dout(rgray_s)
  );

  dcf_wside #(.AW(AW)) u_wside (
    .clk(wr_clk), .clr(clr_w), .wr_req(wr_req), .rgray_s(rgray_s),
    .ofs_f(ofs_f), .wbin(wbin), .wgray(wgray), .full(full_w),
    .half_full(half_full), .almost_full(almost_full), .we(we), .wa(wa)
  );

  dcf_rside #(.AW(AW), .DW(DW)) u_rside (
    .clk(rd_clk), .clr(clr_r), .rd_req(rd_req), .rewind(rewind),
    .wgray_s(wgray_s), .ofs_e(ofs_e), .head(head), .rbin(rbin),
    .rgray(rgray), .empty(empty_r), .almost_empty(almost_empty),
    .ra(ra), .q_std(q_std)
  );

  always_ff @(posedge wr_clk) begin
    if (we) mem[wa] <= din;
  end

  assign head     = mem[ra];
  assign dout     = (mode_r == MODE_FWFT) ? head : q_std;
  assign out_flag = (mode_r == MODE_FWFT) ? !empty_r : empty_r;
  assign in_flag  = (mode_w == MODE_FWFT) ? !full_w : full_w;
endmodule

// File: rtl/dualclk_fifo_chk.sv
`timescale 1ns/1ps
module dualclk_fifo_chk #(
  parameter int AW = 4
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_all_n,
  input logic        rst_ptr_n,
  input logic        wr_req,
  input logic        rd_req,
  input logic        rewind,
  input logic        full_w,
  input logic        empty_r,
  input logic        half_full,
  input logic        almost_full,
  input logic        mode_w,
  input logic [AW:0] wbin,
  input logic [AW:0] rbin,
  input logic [AW:0] wgray
);
  logic live_w = 1'b0;
  always_ff @(posedge wclk) live_w <= rst_all_n && rst_ptr_n;

  // R5: a write attempt while full leaves the write pointer alone
  a_r5_no_overflow: assert property (@(posedge wclk)
    disable iff (!rst_all_n || !rst_ptr_n)
    (wr_req && full_w) |=> $stable(wbin));

  // R5: a read attempt while empty leaves the read pointer alone
  a_r5_no_underflow: assert property (@(posedge rclk)
    disable iff (!rst_all_n || !rst_ptr_n)
    (rd_req && !rewind && empty_r) |=> $stable(rbin));

  // R12: rewind returns the read pointer to location 0
  a_r12_rewind_zero: assert property (@(posedge rclk)
    disable iff (!rst_all_n || !rst_ptr_n)
    rewind |=> (rbin == '0));

  // R11: pointer-only reset clears the write pointer
  a_r11_ptr_clear: assert property (@(posedge wclk)
    disable iff (!rst_all_n)
    !rst_ptr_n |=> (wbin == '0));

  // R11: pointer-only reset keeps the mode
  a_r11_mode_kept: assert property (@(posedge wclk)
    disable iff (!rst_all_n)
    !rst_ptr_n |=> $stable(mode_w));

  // R7: a full buffer is also more than half full
  a_r7_full_has_half: assert property (@(posedge wclk)
    disable iff (!rst_all_n || !rst_ptr_n)
    full_w |-> half_full);

  // R8: a full buffer is also almost full
  a_r8_full_has_almost: assert property (@(posedge wclk)
    disable iff (!rst_all_n || !rst_ptr_n)
    full_w |-> almost_full);

  // R13: the crossing write pointer moves by at most one Gray bit per edge
  a_r13_gray_step: assert property (@(posedge wclk)
    disable iff (!rst_all_n || !rst_ptr_n)
    live_w |-> ($countones(wgray ^ $past(wgray)) <= 1));
endmodule

bind dualclk_fifo dualclk_fifo_chk #(.AW(AW)) u_chk (
  .wclk(wr_clk), .rclk(rd_clk), .rst_all_n(rst_all_n), .rst_ptr_n(rst_ptr_n),
  .wr_req(wr_req), .rd_req(rd_req), .rewind(rewind), .full_w(full_w),
  .empty_r(empty_r), .half_full(half_full), .almost_full(almost_full),
  .mode_w(mode_w), .wbin(wbin), .rbin(rbin), .wgray(wgray)
);

// File: tb/sim_dualclk_fifo.sv
`timescale 1ns/1ps
module sim_dualclk_fifo;
  localparam int DW    = 9;
  localparam int AW    = 4;
  localparam int DEPTH = 16;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic rst_all_n = 1'b0, rst_ptr_n = 1'b1, fall_thru = 1'b0;
  logic wr_en_n = 1'b1, ofs_ld_n = 1'b1, rd_en_n = 1'b1, rewind_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic out_flag, in_flag, half_full, almost_empty, almost_full;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 wr_clk = ~wr_clk;
  initial begin
    #1;
    forever #2 rd_clk = ~rd_clk;
  end

  dualclk_fifo #(.DW(DW), .AW(AW)) u0 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_all_n(rst_all_n),
    .rst_ptr_n(rst_ptr_n), .fall_thru(fall_thru), .wr_en_n(wr_en_n),
    .ofs_ld_n(ofs_ld_n), .din(din), .rd_en_n(rd_en_n), .rewind_n(rewind_n),
    .dout(dout), .out_flag(out_flag), .in_flag(in_flag),
    .half_full(half_full), .almost_empty(almost_empty),
    .almost_full(almost_full)
  );

  function automatic logic [DW-1:0] pat(input int k);
    return DW'((k * 37 + 11) % 512);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic full_reset(input logic fw, input logic ldsel);
    @(negedge wr_clk);
    rst_all_n = 1'b0; fall_thru = fw; ofs_ld_n = ldsel;
    repeat (3) @(negedge wr_clk);
    rst_all_n = 1'b1; fall_thru = 1'b0; ofs_ld_n = 1'b1;
    repeat (3) @(negedge wr_clk);
  endtask

  task automatic ptr_reset();
    @(negedge wr_clk);
    rst_ptr_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    rst_ptr_n = 1'b1;
    repeat (3) @(negedge wr_clk);
  endtask

  task automatic wr(input logic [DW-1:0] v);
    @(negedge wr_clk);
    wr_en_n = 1'b0; din = v;
    @(posedge wr_clk);
    #0.5 wr_en_n = 1'b1;
  endtask

  task automatic load_ofs(input logic [DW-1:0] v);
    @(negedge wr_clk);
    wr_en_n = 1'b0; ofs_ld_n = 1'b0; din = v;
    @(posedge wr_clk);
    #0.5 wr_en_n = 1'b1; ofs_ld_n = 1'b1;
  endtask

  task automatic rd();
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    @(posedge rd_clk);
    #0.5 rd_en_n = 1'b1;
  endtask

  task automatic rwd();
    @(negedge rd_clk);
    rewind_n = 1'b0;
    @(posedge rd_clk);
    #0.5 rewind_n = 1'b1;
  endtask

  task automatic settle();
    repeat (6) @(negedge wr_clk);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int edges;
    // ---- standard mode, high default pair (empty 5, full 6)
    full_reset(1'b0, 1'b1);
    chk("R1 out_flag empty", out_flag, 1);
    chk("R1 in_flag", in_flag, 0);
    chk("R1 half_full", half_full, 0);
    chk("R1 almost_empty", almost_empty, 1);
    chk("R1 almost_full", almost_full, 0);
    chk("R1 dout", dout, 0);

    for (int k = 1; k <= DEPTH; k++) begin
      wr(pat(k));
      chk("R6 full on filling edge", in_flag, (k == DEPTH) ? 1 : 0);
      settle();
      chk("R2 std out_flag", out_flag, 0);
      chk("R7 half_full", half_full, (k > DEPTH/2) ? 1 : 0);
      chk("R9 R8 almost_full hi default", almost_full, (k >= DEPTH - 6) ? 1 : 0);
      chk("R9 R8 almost_empty hi default", almost_empty, (k <= 5) ? 1 : 0);
    end
    wr(9'h1FF);   // R5 overflow attempt
    settle();
    chk("R5 full kept", in_flag, 1);

    for (int j = 0; j < DEPTH; j++) begin
      rd();
      chk("R3 data order", dout, pat(j + 1));
      chk("R6 empty on last read edge", out_flag, (j == DEPTH - 1) ? 1 : 0);
      settle();
      chk("R7 half_full drain", half_full, (DEPTH - 1 - j > DEPTH/2) ? 1 : 0);
      chk("R8 almost_empty drain", almost_empty, (DEPTH - 1 - j <= 5) ? 1 : 0);
      chk("R8 almost_full drain", almost_full, (DEPTH - 1 - j >= DEPTH - 6) ? 1 : 0);
    end
    rd();         // R5 underflow attempt
    chk("R5 dout unchanged", dout, pat(DEPTH));
    settle();
    chk("R5 still empty", out_flag, 1);
    wr(pat(40));
    settle();
    rd();
    chk("R5 read pointer not moved", dout, pat(40));

    // ---- R13 crossing latency
    wr(pat(50));
    edges = 0;
    while (out_flag == 1'b1 && edges < 8) begin
      @(posedge rd_clk); #0.5; edges++;
    end
    chk("R13 empty clears within 3 rd edges", (edges <= 3) ? 1 : 0, 1);
    for (int k = 51; k < 51 + DEPTH - 1; k++) wr(pat(k));
    chk("R13 full reached", in_flag, 1);
    rd();
    edges = 0;
    while (in_flag == 1'b1 && edges < 8) begin
      @(posedge wr_clk); #0.5; edges++;
    end
    chk("R13 full clears within 3 wr edges", (edges <= 3) ? 1 : 0, 1);

    // ---- R11 pointer reset, R10 offset load
    ptr_reset();
    chk("R11 empty after ptr reset", out_flag, 1);
    chk("R11 not full", in_flag, 0);
    chk("R11 half_full", half_full, 0);
    load_ofs(9'd3);
    load_ofs(9'd1);
    settle();
    chk("R10 load stores no word", out_flag, 1);
    for (int k = 1; k < DEPTH; k++) begin
      wr(pat(60 + k));
      settle();
      chk("R10 almost_empty loaded 3", almost_empty, (k <= 3) ? 1 : 0);
      chk("R10 almost_full loaded 1", almost_full, (k >= DEPTH - 1) ? 1 : 0);
    end
    rd();
    chk("R10 first word is data", dout, pat(61));
    ptr_reset();
    for (int k = 1; k <= 4; k++) wr(pat(70 + k));
    settle();
    chk("R11 offsets kept", almost_empty, 0);

    // ---- R12 rewind, standard mode
    ptr_reset();
    for (int k = 1; k <= 5; k++) wr(pat(100 + k));
    settle();
    for (int k = 1; k <= 3; k++) begin
      rd();
      chk("R12 pre-rewind read", dout, pat(100 + k));
    end
    rwd();
    for (int k = 1; k <= 5; k++) begin
      rd();
      chk("R12 replay", dout, pat(100 + k));
    end
    chk("R12 empty after replay", out_flag, 1);

    // ---- fall-through mode, low default pair (empty 2, full 3)
    full_reset(1'b1, 1'b0);
    chk("R2 fwft not ready", out_flag, 0);
    chk("R2 fwft input ready", in_flag, 1);
    chk("R1 fwft almost_empty", almost_empty, 1);
    for (int k = 1; k <= DEPTH; k++) begin
      wr(pat(200 + k));
      settle();
      chk("R4 ready", out_flag, 1);
      chk("R4 head without strobe", dout, pat(201));
      chk("R9 almost_empty lo default", almost_empty, (k <= 2) ? 1 : 0);
      chk("R9 almost_full lo default", almost_full, (k >= DEPTH - 3) ? 1 : 0);
      chk("R7 half_full fwft", half_full, (k > DEPTH/2) ? 1 : 0);
      chk("R2 input ready", in_flag, (k < DEPTH) ? 1 : 0);
    end
    wr(9'h0AA);   // R5 ignored
    for (int j = 0; j < DEPTH; j++) begin
      chk("R4 fwft order", dout, pat(201 + j));
      rd();
      chk("R6 not ready on last read edge", out_flag, (j == DEPTH - 1) ? 0 : 1);
    end
    for (int k = 1; k <= 3; k++) wr(pat(300 + k));
    settle();
    rd();
    chk("R4 advance", dout, pat(302));
    rwd();
    chk("R12 fwft rewind head", dout, pat(301));

    ptr_reset();
    wr(pat(400));
    settle();
    chk("R11 mode kept ready", out_flag, 1);
    chk("R11 mode kept head", dout, pat(400));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule